// File: doc/BRIEF.md
# Handset Dialing Sequencer

This block steps a handset telephone through the states a user sees: waiting on-hook, listening to a dial tone, holding a key, waiting for more digits, calling, hearing that the far end has hung up, and falling asleep after a long silence. Upstream logic has already scanned and debounced the keypad; it supplies a key-held level with a 4-bit key code, the R key level, a reset switch, the hook switch and a far-end hangup event. Downstream logic turns the tone select code into audio and uses the place-call strobe and the digit buffer to set up the call.

Dialing works by key release. Each released key is appended to a 16-entry digit buffer. The first stored digit silences the dial tone. Every release restarts an inter-digit timer, and when that timer runs out the sequencer enters the call state and pulses the place-call strobe. While the buffer is empty, the same timer measures how long the user has been idle: it raises an alert tone first and then a sleep request. Holding R while lifting the handset selects speed-dial mode. Holding R while dialing or during a call selects command mode, and releasing R returns to the state that command mode was entered from.

States: IDLE (on-hook), DIAL (dialing), KEY (key held), CALL (call placed or active), HUP (far end hung up), SPEED (speed dial), CMD (command mode), SLEEP. Transitions:
- IDLE→DIAL or IDLE→SPEED on off-hook.
- DIAL→KEY on a key press.
- KEY→DIAL on release, which stores the digit.
- DIAL→CALL when the inter-digit timer expires.
- DIAL→SLEEP when the idle timer expires.
- DIAL→CMD and CALL→CMD on R, then CMD→DIAL or CMD→CALL when R is released.
- CALL→HUP on a far-end hangup.
- Any state→IDLE on-hook.
- Any off-hook state→DIAL on the reset switch.

Top module: `handset_call_ctrl`

## Requirements
- R1: Reset and going on-hook put the block in IDLE one cycle later: tone_sel is 0 (silent), digit_count is 0, overflow is 0, and the mode outputs are low.
- R2: Lifting the handset with R released enters DIAL on the next cycle. In DIAL, tone_sel is 1 (dial tone) while the buffer is empty and the alert time has not been reached.
- R3: A key held in DIAL moves to KEY on the next cycle. In KEY, tone_sel is 2 (key tone) and tone_key carries the key code latched at entry, until the key is released.
- R4: The edge that sees the key released returns to DIAL. It writes the digit to slot digit_count, which occupies digits bits [4*i+3:4*i], and increments digit_count. With at least one digit stored, tone_sel is 0 in DIAL.
- R5: With at least one digit stored and no input, the block stays in DIAL for T_DIGIT cycles after the release edge and then enters CALL. place_call is high for exactly the first cycle of CALL, which is T_DIGIT+1 edges after the release edge.
- R6: A far_hangup pulse in CALL moves to HUP. In HUP, tone_sel is 3 until on-hook.
- R7: With an empty buffer and no input, tone_sel becomes 4 (alert) T_ALERT+1 edges after the edge that entered DIAL.
- R8: After a further T_SLEEP cycles with no input, the block enters SLEEP. In SLEEP, sleep_req is high and tone_sel is 0.
- R9: While off-hook, reset_sw returns the block to DIAL with an empty buffer and the dial tone on.
- R10: If R is held on the edge that sees off-hook, the block enters SPEED (speed_dial high, silent) and stays there until on-hook.
- R11: R held in DIAL or CALL enters CMD (cmd_mode high). Releasing R returns to the state CMD was entered from. Returning to CALL does not pulse place_call.
- R12: A key pressed while 16 digits are stored is ignored: digit_count, the buffer contents and tone_sel are unchanged. The press sets overflow, which stays set until on-hook or reset_sw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| off_hook | input | 1 | Handset lifted |
| key_held | input | 1 | A debounced key is down |
| key_code | input | 4 | Code of the held key |
| r_key | input | 1 | R key held |
| reset_sw | input | 1 | Reset switch |
| far_hangup | input | 1 | Far end hung up (pulse) |
| tone_sel | output | 3 | 0 silent, 1 dial, 2 key tone, 3 hangup, 4 alert |
| tone_key | output | 4 | Key code for the key tone |
| place_call | output | 1 | One-cycle call request |
| sleep_req | output | 1 | Sleep request |
| speed_dial | output | 1 | Speed-dial mode active |
| cmd_mode | output | 1 | Command mode active |
| digit_count | output | 5 | Number of stored digits |
| digits | output | 64 | Stored digits, slot i at bits [4*i+3:4*i] |
| overflow | output | 1 | Sticky full-buffer press flag |

## Verification
The hardest condition to reach from the ports is a key press into a full buffer. It needs sixteen complete press and release cycles, and each release must come before the inter-digit timer expires; otherwise the block places a call before the buffer fills. The stimulus therefore uses short holds, fills all sixteen slots with distinct codes, and then checks that the seventeenth press changes neither the count, the last slot nor the tone, while overflow rises and stays up. Timer expiry instants are measured by counting edges from the triggering edge up to the first cycle in which the output changes.

// File: rtl/hc_pkg.sv
package hc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_DIAL, ST_KEY, ST_CALL, ST_HUP, ST_SPEED, ST_CMD, ST_SLEEP
    } state_e;

    typedef enum logic [2:0] {
        TN_OFF   = 3'd0,
        TN_DIAL  = 3'd1,
        TN_DTMF  = 3'd2,
        TN_HUP   = 3'd3,
        TN_ALERT = 3'd4
    } tone_e;
endpackage

// File: rtl/hc_digit_buf.sv
module hc_digit_buf #(
    parameter int DEPTH = 16,
    parameter int DW    = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                push,
    input  logic [DW-1:0]       din,
    output logic [CW-1:0]       count,
    output logic                full,
    output logic [DEPTH*DW-1:0] flat
);
    localparam logic [CW-1:0] FULL_AT = CW'(DEPTH);

    assign full = (count == FULL_AT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               count <= '0;
        else if (clr)             count <= '0;
        else if (push && !full)   count <= count + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              flat[g*DW +: DW] <= '0;
            else if (clr)                            flat[g*DW +: DW] <= '0;
            else if (push && count == CW'(g))        flat[g*DW +: DW] <= din;
        end
    end
endmodule

// File: rtl/hc_tick_timer.sv
module hc_tick_timer #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    output logic [TW-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  value <= '0;
        else if (restart)            value <= '0;
        else if (run && value != '1) value <= value + 1'b1;
    end
endmodule

// File: rtl/handset_call_ctrl.sv
module handset_call_ctrl
    import hc_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int KW      = 4,
    parameter int T_DIGIT = 400000,
    parameter int T_ALERT = 2000000,
    parameter int T_SLEEP = 6000000,
    parameter int CW      = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                off_hook,
    input  logic                key_held,
    input  logic [KW-1:0]       key_code,
    input  logic                r_key,
    input  logic                reset_sw,
    input  logic                far_hangup,
    output logic [2:0]          tone_sel,
    output logic [KW-1:0]       tone_key,
    output logic                place_call,
    output logic                sleep_req,
    output logic                speed_dial,
    output logic                cmd_mode,
    output logic [CW-1:0]       digit_count,
    output logic [DEPTH*KW-1:0] digits,
    output logic                overflow
);
    localparam int TW = $clog2(T_DIGIT + T_ALERT + T_SLEEP + 2);
    localparam logic [TW-1:0] DIGIT_LAST = TW'(T_DIGIT - 1);
    localparam logic [TW-1:0] ALERT_AT   = TW'(T_ALERT);
    localparam logic [TW-1:0] SLEEP_LAST = TW'(T_ALERT + T_SLEEP - 1);

    state_e          state_q, state_d;
    logic [KW-1:0]   key_q;
    logic            cmd_ret_q;
    logic            ovf_q, ovf_set;
    logic            call_q, go_call;
    logic            push, clr, full;
    logic [TW-1:0]   tmr;
    tone_e           tone;

    assign clr = !off_hook || reset_sw;

    hc_digit_buf #(.DEPTH(DEPTH), .DW(KW), .CW(CW)) buf_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .din(key_q),
        .count(digit_count), .full(full), .flat(digits)
    );

    hc_tick_timer #(.TW(TW)) tmr_i (
        .clk(clk), .rst_n(rst_n),
        .restart((state_d != state_q) || reset_sw),
        .run(state_q == ST_DIAL),
        .value(tmr)
    );

    // next-state and transition events
    always_comb begin
        state_d = state_q;
        push    = 1'b0;
        ovf_set = 1'b0;
        go_call = 1'b0;
        if (!off_hook) begin
            state_d = ST_IDLE;
        end else if (reset_sw) begin
            state_d = ST_DIAL;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = r_key ? ST_SPEED : ST_DIAL;
                ST_DIAL: begin
                    if (r_key) begin
                        state_d = ST_CMD;
                    end else if (key_held) begin
                        if (full) ovf_set = 1'b1;
                        else      state_d = ST_KEY;
                    end else if (digit_count != '0) begin
                        if (tmr == DIGIT_LAST) begin
                            state_d = ST_CALL;
                            go_call = 1'b1;
                        end
                    end else if (tmr == SLEEP_LAST) begin
                        state_d = ST_SLEEP;
                    end
                end
                ST_KEY: begin
                    if (!key_held) begin
                        push    = 1'b1;
                        state_d = ST_DIAL;
                    end
                end
                ST_CALL: begin
                    if (far_hangup) state_d = ST_HUP;
                    else if (r_key) state_d = ST_CMD;
                end
                ST_CMD:   if (!r_key) state_d = cmd_ret_q ? ST_CALL : ST_DIAL;
                ST_HUP, ST_SPEED, ST_SLEEP: state_d = state_q;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            key_q     <= '0;
            cmd_ret_q <= 1'b0;
            ovf_q     <= 1'b0;
            call_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            call_q  <= go_call;
            if (state_q == ST_DIAL && state_d == ST_KEY) key_q <= key_code;
            if (state_d == ST_CMD && state_q != ST_CMD)  cmd_ret_q <= (state_q == ST_CALL);
            if (clr)          ovf_q <= 1'b0;
            else if (ovf_set) ovf_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_DIAL: begin
                if (digit_count != '0)  tone = TN_OFF;
                else if (tmr >= ALERT_AT) tone = TN_ALERT;
                else                    tone = TN_DIAL;
            end
            ST_KEY:  tone = TN_DTMF;
            ST_HUP:  tone = TN_HUP;
            default: tone = TN_OFF;
        endcase
    end

    assign tone_sel   = tone;
    assign tone_key   = (state_q == ST_KEY) ? key_q : '0;
    assign place_call = call_q;
    assign sleep_req  = (state_q == ST_SLEEP);
    assign speed_dial = (state_q == ST_SPEED);
    assign cmd_mode   = (state_q == ST_CMD);
    assign overflow   = ovf_q;
endmodule

// File: rtl/hc_checker.sv
module hc_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          off_hook,
    input logic          reset_sw,
    input logic [2:0]    tone_sel,
    input logic          place_call,
    input logic          sleep_req,
    input logic [CW-1:0] digit_count,
    input logic          overflow
);
    a_r1_onhook_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !off_hook |=> (tone_sel == 3'd0 && digit_count == '0 && !overflow));

    a_r5_call_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        place_call |=> !place_call);

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (off_hook && !reset_sw) |=>
            (digit_count == $past(digit_count) || digit_count == $past(digit_count) + 1'b1));

    a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        digit_count <= CW'(DEPTH));

    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && off_hook && !reset_sw) |=> overflow);

    a_r6_hup_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_sel == 3'd3 && off_hook && !reset_sw) |=> tone_sel == 3'd3);

    a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && off_hook && !reset_sw) |=> (sleep_req && tone_sel == 3'd0));
endmodule

bind handset_call_ctrl hc_checker #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .off_hook(off_hook), .reset_sw(reset_sw),
    .tone_sel(tone_sel), .place_call(place_call), .sleep_req(sleep_req),
    .digit_count(digit_count), .overflow(overflow)
);

// File: tb/handset_call_ctrl_tb_top.sv
`timescale 1ns/1ps
module handset_call_ctrl_tb_top;
    localparam int DEPTH = 16;
    localparam int TD = 20;
    localparam int TA = 30;
    localparam int TS = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic off_hook = 0, key_held = 0, r_key = 0, reset_sw = 0, far_hangup = 0;
    logic [3:0] key_code = '0;
    logic [2:0] tone_sel;
    logic [3:0] tone_key;
    logic place_call, sleep_req, speed_dial, cmd_mode, overflow;
    logic [4:0] digit_count;
    logic [63:0] digits;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    handset_call_ctrl #(.DEPTH(DEPTH), .T_DIGIT(TD), .T_ALERT(TA), .T_SLEEP(TS)) dut_i (
        .clk(clk), .rst_n(rst_n), .off_hook(off_hook), .key_held(key_held),
        .key_code(key_code), .r_key(r_key), .reset_sw(reset_sw), .far_hangup(far_hangup),
        .tone_sel(tone_sel), .tone_key(tone_key), .place_call(place_call),
        .sleep_req(sleep_req), .speed_dial(speed_dial), .cmd_mode(cmd_mode),
        .digit_count(digit_count), .digits(digits), .overflow(overflow)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_offhook();
        off_hook = 0; step();
        off_hook = 1; step();
    endtask

    task automatic press(input logic [3:0] code, input int hold);
        key_code = code; key_held = 1; step();
        check("R3 key tone", tone_sel, 2);
        check("R3 key code", tone_key, code);
        repeat (hold) step();
        check("R3 tone held", tone_sel, 2);
        key_held = 0; step();
    endtask

    task automatic t_reset();
        check("R1 reset tone", tone_sel, 0);
        check("R1 reset count", digit_count, 0);
        check("R1 reset ovf", overflow, 0);
        check("R1 reset modes", {speed_dial, cmd_mode, sleep_req}, 0);
    endtask

    task automatic t_capture_and_call();
        int n;
        go_offhook();
        check("R2 dial tone", tone_sel, 1);
        press(4'd5, 3);
        check("R4 count1", digit_count, 1);
        check("R4 slot0", digits[3:0], 5);
        check("R4 dial off", tone_sel, 0);
        press(4'd9, 1);
        press(4'd12, 0);
        check("R4 count3", digit_count, 3);
        check("R4 slot1", digits[7:4], 9);
        check("R4 slot2", digits[11:8], 12);
        n = 1;
        while (!place_call && n < 200) begin step(); n++; end
        check("R5 call delay", n, TD + 1);
        step();
        check("R5 pulse width", place_call, 0);
        far_hangup = 1; step(); far_hangup = 0;
        check("R6 hangup tone", tone_sel, 3);
        repeat (3) step();
        check("R6 hangup held", tone_sel, 3);
        off_hook = 0; step();
        check("R1 onhook tone", tone_sel, 0);
        check("R1 onhook count", digit_count, 0);
    endtask

    task automatic t_alert_sleep();
        int n;
        off_hook = 1; step();
        n = 1;
        while (tone_sel != 3'd4 && n < 500) begin step(); n++; end
        check("R7 alert time", n, TA + 1);
        while (!sleep_req && n < 500) begin step(); n++; end
        check("R8 sleep time", n, TA + TS + 1);
        check("R8 sleep silent", tone_sel, 0);
        off_hook = 0; step();
    endtask

    task automatic t_reset_sw();
        go_offhook();
        press(4'd1, 0);
        press(4'd2, 0);
        reset_sw = 1; step(); reset_sw = 0;
        check("R9 count cleared", digit_count, 0);
        check("R9 dial tone", tone_sel, 1);
        off_hook = 0; step();
    endtask

    task automatic t_speed();
        r_key = 1; off_hook = 1; step();
        check("R10 speed", speed_dial, 1);
        check("R10 silent", tone_sel, 0);
        r_key = 0; step();
        check("R10 stays", speed_dial, 1);
        off_hook = 0; step();
        check("R1 speed cleared", speed_dial, 0);
    endtask

    task automatic t_command();
        int n;
        go_offhook();
        r_key = 1; step();
        check("R11 cmd from dial", cmd_mode, 1);
        r_key = 0; step();
        check("R11 back to dial", tone_sel, 1);
        press(4'd3, 0);
        n = 0;
        while (!place_call && n < 200) begin step(); n++; end
        r_key = 1; step();
        check("R11 cmd from call", cmd_mode, 1);
        r_key = 0; step();
        check("R11 cmd left", cmd_mode, 0);
        check("R11 no repulse", place_call, 0);
        far_hangup = 1; step(); far_hangup = 0;
        check("R11 back in call", tone_sel, 3);
        off_hook = 0; step();
    endtask

    task automatic t_overflow();
        go_offhook();
        for (int i = 0; i < DEPTH; i++) press(4'(i), 0);
        check("R12 full count", digit_count, DEPTH);
        key_code = 4'd7; key_held = 1; step();
        check("R12 ignored tone", tone_sel, 0);
        check("R12 ovf set", overflow, 1);
        key_held = 0; step();
        check("R12 count kept", digit_count, DEPTH);
        check("R12 last slot", digits[63:60], 15);
        check("R12 ovf sticky", overflow, 1);
        off_hook = 0; step();
        check("R1 ovf cleared", overflow, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_capture_and_call();
        t_alert_sleep();
        t_reset_sw();
        t_speed();
        t_command();
        t_overflow();
        finish_run();
    end
endmodule